// File: doc/BRIEF.md
# I2C Master Acknowledge and Stop Sequencer

This block is the tail end of an I2C master. Once a byte transfer has finished and the master holds SCL low, it drives either the acknowledge bit for a received byte or a STOP condition onto the open-drain SCL and SDA lines. It does this through two pull-low enables, and it reads the lines back through two-flop synchronisers.

Every timed phase uses one internal down-counter. The counter is reloaded from the `RELOAD` parameter, so each phase lasts `RELOAD+1` clock cycles. Whenever the block releases a line, it waits until the line is actually sampled at the released level before it starts the next period. This lets a slave stretch the clock.

The surrounding master starts a sequence with a one-cycle request. It watches the busy output and the self-clearing request bits, and it receives a sticky interrupt when a sequence ends. Writes to the transmit buffer are gated by this block: a write made during a sequence is refused and flagged as a collision.

Top module: `i2c_ackstop_seq`

## Requirements
- R1: After reset, both pull-low enables, `busy`, `ack_en`, `stop_en`, `irq`, `stop_seen` and `wcol` are 0.
- R2: When idle, an `ack_req` pulse is accepted at the next clock edge. From then on, `scl_pull` is 1 and `sda_pull` equals the inverse of `ack_bit` (0 = ACK = SDA pulled, 1 = NACK = SDA released). `scl_pull` stays 1 for exactly `RELOAD+1` cycles.
- R3: After SCL is released in the acknowledge sequence, the block waits for as long as the line is held low externally. `scl_pull` returns to 1 exactly `RELOAD+4` clock edges after the line goes high: two synchroniser stages, one detection edge, and one period.
- R4: At the end of the acknowledge sequence, `ack_en` clears, `irq` sets, `busy` drops and `sda_pull` drops. `scl_pull` stays at 1, so SCL is held low.
- R5: When idle, a `stop_req` is accepted only while the synchronised SCL is low. Otherwise it is ignored: `busy` and `sda_pull` stay 0.
- R6: An accepted STOP pulls SDA low at once. After SDA is sampled low, one period runs. `scl_pull` drops `RELOAD+4` edges after acceptance.
- R7: After SCL is released in the STOP sequence, the block waits for SCL to be sampled high. `sda_pull` drops `RELOAD+4` edges after the SCL line goes high.
- R8: `stop_seen` sets 3 edges after SDA is released, once SDA and SCL are both sampled high. It clears when the next request is accepted.
- R9: `RELOAD+1` edges after `stop_seen` sets, `stop_en` clears, `irq` sets and `busy` drops.
- R10: A `buf_wr` pulse while idle gives `buf_load` = 1 in the same cycle. A `buf_wr` pulse while busy gives `buf_load` = 0 and sets `wcol` at the next edge.
- R11: If `ack_req` and `stop_req` arrive in the same cycle, the acknowledge is taken. Requests that arrive while `busy` is 1 are ignored.
- R12: `irq` and `wcol` stay set until `irq_clr` or `wcol_clr`, respectively, is pulsed. A set event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_req | input | 1 | Start acknowledge sequence (pulse) |
| ack_bit | input | 1 | Acknowledge data: 0 = ACK, 1 = NACK |
| stop_req | input | 1 | Start STOP sequence (pulse) |
| buf_wr | input | 1 | Transmit buffer write strobe |
| irq_clr | input | 1 | Clears `irq` |
| wcol_clr | input | 1 | Clears `wcol` |
| scl_in | input | 1 | SCL line level from the pin |
| sda_in | input | 1 | SDA line level from the pin |
| scl_pull | output | 1 | Pull SCL low when 1 |
| sda_pull | output | 1 | Pull SDA low when 1 |
| busy | output | 1 | A sequence is running |
| ack_en | output | 1 | Acknowledge request bit, self-clearing |
| stop_en | output | 1 | STOP request bit, self-clearing |
| irq | output | 1 | Sticky sequence-done flag |
| stop_seen | output | 1 | STOP condition detected |
| wcol | output | 1 | Sticky write-collision flag |
| buf_load | output | 1 | Buffer write accepted |

## Verification
Some properties are checked on every cycle, whatever the stimulus:
- the two request bits are mutually exclusive;
- a write while busy always leaves a collision flag;
- each self-clearing request falls together with the interrupt and with the correct line state;
- `stop_seen` rises only with both lines released during a STOP.

Other behaviour only the bench's scenarios can show. This includes the exact phase lengths, the wait under clock stretching of varying length, the ACK/NACK level on SDA, the rejection of a STOP while SCL is high, and request priority.

// File: rtl/i2c_ackstop_seq.sv
module i2c_ackstop_seq #(
  parameter int RELOAD = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_req,
  input  logic ack_bit,
  input  logic stop_req,
  input  logic buf_wr,
  input  logic irq_clr,
  input  logic wcol_clr,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_pull,
  output logic sda_pull,
  output logic busy,
  output logic ack_en,
  output logic stop_en,
  output logic irq,
  output logic stop_seen,
  output logic wcol,
  output logic buf_load
);
  localparam int CW = (RELOAD < 2) ? 1 : $clog2(RELOAD + 1);
  localparam logic [CW-1:0] LOAD = CW'(RELOAD);

  typedef enum logic [3:0] {
    IDLE, A_LOW, A_WAIT, A_HIGH, S_SDA, S_CNT1, S_WSCL, S_CNT2, S_WSDA, S_CNT3
  } st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic [1:0] scl_q, sda_q;
  logic ackb, hold;

  wire scl_s = scl_q[1];
  wire sda_s = sda_q[1];
  wire tmo   = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 2'b11;
      sda_q <= 2'b11;
    end else begin
      scl_q <= {scl_q[0], scl_in};
      sda_q <= {sda_q[0], sda_in};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st        <= IDLE;
      cnt       <= '0;
      ackb      <= 1'b1;
      hold      <= 1'b0;
      ack_en    <= 1'b0;
      stop_en   <= 1'b0;
      irq       <= 1'b0;
      stop_seen <= 1'b0;
      wcol      <= 1'b0;
    end else begin
      if (irq_clr)  irq  <= 1'b0;
      if (wcol_clr) wcol <= 1'b0;
      if (buf_wr && busy) wcol <= 1'b1;
      case (st)
        IDLE:
          if (ack_req) begin
            st <= A_LOW; cnt <= LOAD; ackb <= ack_bit;
            ack_en <= 1'b1; stop_seen <= 1'b0; hold <= 1'b0;
          end else if (stop_req && !scl_s) begin
            st <= S_SDA; stop_en <= 1'b1; stop_seen <= 1'b0;
          end
        A_LOW:
          if (tmo) st <= A_WAIT;
          else     cnt <= cnt - 1'b1;
        A_WAIT:
          if (scl_s) begin st <= A_HIGH; cnt <= LOAD; end
        A_HIGH:
          if (tmo) begin
            st <= IDLE; ack_en <= 1'b0; irq <= 1'b1; hold <= 1'b1;
          end else cnt <= cnt - 1'b1;
        S_SDA:
          if (!sda_s) begin st <= S_CNT1; cnt <= LOAD; end
        S_CNT1:
          if (tmo) begin st <= S_WSCL; hold <= 1'b0; end
          else     cnt <= cnt - 1'b1;
        S_WSCL:
          if (scl_s) begin st <= S_CNT2; cnt <= LOAD; end
        S_CNT2:
          if (tmo) st <= S_WSDA;
          else     cnt <= cnt - 1'b1;
        S_WSDA:
          if (sda_s && scl_s) begin
            st <= S_CNT3; cnt <= LOAD; stop_seen <= 1'b1;
          end
        S_CNT3:
          if (tmo) begin st <= IDLE; stop_en <= 1'b0; irq <= 1'b1; end
          else     cnt <= cnt - 1'b1;
        default: st <= IDLE;
      endcase
    end

  assign busy     = (st != IDLE);
  assign buf_load = buf_wr && !busy;
  assign scl_pull = hold || (st inside {A_LOW, S_SDA, S_CNT1});
  assign sda_pull = ((st inside {A_LOW, A_WAIT, A_HIGH}) && !ackb) ||
                    (st inside {S_SDA, S_CNT1, S_WSCL, S_CNT2});
endmodule

// File: rtl/i2c_ackstop_chk.sv
module i2c_ackstop_chk (
  input logic clk,
  input logic rst_n,
  input logic ack_en,
  input logic stop_en,
  input logic busy,
  input logic irq,
  input logic stop_seen,
  input logic wcol,
  input logic buf_wr,
  input logic scl_pull,
  input logic sda_pull
);
  // R11
  excl_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_en && stop_en));

  // R10
  wcol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr && busy) |=> wcol);

  // R4
  ack_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_en) |-> (irq && !busy && scl_pull && !sda_pull));

  // R9
  stop_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_en) |-> (irq && stop_seen && !busy));

  // R8
  stop_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_seen) |-> (stop_en && !sda_pull && !scl_pull));
endmodule

bind i2c_ackstop_seq i2c_ackstop_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ack_en(ack_en), .stop_en(stop_en),
  .busy(busy), .irq(irq), .stop_seen(stop_seen), .wcol(wcol),
  .buf_wr(buf_wr), .scl_pull(scl_pull), .sda_pull(sda_pull)
);

// File: tb/sim_i2c_ackstop_seq.sv
module sim_i2c_ackstop_seq;
  localparam int RELOAD = 3;
  localparam int NV = 7;
  // {is_stop, ack_bit, stretch[3:0]}
  localparam logic [5:0] VEC [NV] = '{
    6'b0_0_0000, 6'b1_0_0000, 6'b0_1_0010, 6'b1_0_0011,
    6'b0_0_0101, 6'b0_1_0000, 6'b1_0_0001
  };

  logic clk = 0, rst_n = 0;
  logic ack_req = 0, ack_bit = 0, stop_req = 0, buf_wr = 0;
  logic irq_clr = 0, wcol_clr = 0, ext_scl = 0;
  logic scl_pull, sda_pull, busy, ack_en, stop_en, irq, stop_seen, wcol, buf_load;
  wire scl_in = ~(scl_pull | ext_scl);
  wire sda_in = ~sda_pull;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  i2c_ackstop_seq #(.RELOAD(RELOAD)) u0 (
    .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .ack_bit(ack_bit),
    .stop_req(stop_req), .buf_wr(buf_wr), .irq_clr(irq_clr), .wcol_clr(wcol_clr),
    .scl_in(scl_in), .sda_in(sda_in), .scl_pull(scl_pull), .sda_pull(sda_pull),
    .busy(busy), .ack_en(ack_en), .stop_en(stop_en), .irq(irq),
    .stop_seen(stop_seen), .wcol(wcol), .buf_load(buf_load));

  task automatic tick(); @(posedge clk); #2; endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_irq();
    irq_clr = 1; tick(); irq_clr = 0;
    chk("R12 irq cleared", irq, 0);
  endtask

  task automatic run_ack(input logic b, input int stretch);
    int n;
    ack_req = 1; ack_bit = b; tick(); ack_req = 0;
    chk("R2 scl pulled", scl_pull, 1);
    chk("R2 sda level", sda_pull, !b);
    chk("R2 ack_en", ack_en, 1);
    ext_scl = (stretch > 0);
    n = 0;
    while (scl_pull && n < 100) begin tick(); n++; end
    chk("R2 low time", n, RELOAD + 1);
    if (stretch > 0) begin
      repeat (stretch + 3) tick();
      chk("R3 waits under stretch busy", busy, 1);
      chk("R3 waits under stretch scl", scl_pull, 0);
      ext_scl = 0;
    end
    n = 0;
    while (!scl_pull && n < 100) begin tick(); n++; end
    chk("R3 high time", n, RELOAD + 4);
    chk("R4 ack_en cleared", ack_en, 0);
    chk("R4 irq", irq, 1);
    chk("R4 busy", busy, 0);
    chk("R4 sda released", sda_pull, 0);
    repeat (3) tick();
    chk("R4 scl held", scl_pull, 1);
    chk("R12 irq sticky", irq, 1);
    clear_irq();
  endtask

  task automatic run_stop(input int stretch);
    int n;
    stop_req = 1; tick(); stop_req = 0;
    chk("R6 stop_en", stop_en, 1);
    chk("R6 sda pulled", sda_pull, 1);
    chk("R8 stop_seen cleared on accept", stop_seen, 0);
    ext_scl = (stretch > 0);
    n = 0;
    while (scl_pull && n < 100) begin tick(); n++; end
    chk("R6 scl release delay", n, RELOAD + 4);
    if (stretch > 0) begin
      repeat (stretch + 3) tick();
      chk("R7 waits for scl", sda_pull, 1);
      ext_scl = 0;
    end
    n = 0;
    while (sda_pull && n < 100) begin tick(); n++; end
    chk("R7 sda release delay", n, RELOAD + 4);
    chk("R8 stop_seen not yet", stop_seen, 0);
    n = 0;
    while (!stop_seen && n < 100) begin tick(); n++; end
    chk("R8 stop detect delay", n, 3);
    n = 0;
    while (stop_en && n < 100) begin tick(); n++; end
    chk("R9 finish delay", n, RELOAD + 1);
    chk("R9 irq", irq, 1);
    chk("R9 busy", busy, 0);
    clear_irq();
    repeat (3) tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    tick(); tick();
    chk("R1 scl_pull", scl_pull, 0);
    chk("R1 sda_pull", sda_pull, 0);
    chk("R1 busy", busy, 0);
    chk("R1 flags", {ack_en, stop_en, irq, stop_seen, wcol}, 0);
    rst_n = 1; tick(); tick();

    // R5: SCL high while idle, stop ignored
    stop_req = 1; tick(); stop_req = 0; tick();
    chk("R5 stop ignored busy", busy, 0);
    chk("R5 stop ignored sda", sda_pull, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][5]) run_stop(int'(VEC[i][3:0]));
      else           run_ack(VEC[i][4], int'(VEC[i][3:0]));
    end

    // R5 after completed stop: SCL high again
    stop_req = 1; tick(); stop_req = 0; tick();
    chk("R5 stop ignored after stop", busy, 0);
    chk("R8 stop_seen held", stop_seen, 1);

    // R11 priority and ignore-while-busy; R10 collision
    buf_wr = 1; #1;
    chk("R10 idle write loads", buf_load, 1);
    tick(); buf_wr = 0;
    chk("R10 no wcol idle", wcol, 0);
    ack_req = 1; stop_req = 1; ack_bit = 0; tick(); ack_req = 0; stop_req = 0;
    chk("R11 ack wins", ack_en, 1);
    chk("R11 stop not taken", stop_en, 0);
    chk("R8 stop_seen cleared by ack", stop_seen, 0);
    buf_wr = 1; #1;
    chk("R10 busy write refused", buf_load, 0);
    tick(); buf_wr = 0;
    chk("R10 wcol set", wcol, 1);
    stop_req = 1; tick(); stop_req = 0;
    repeat (2 * RELOAD + 12) tick();
    chk("R11 busy request ignored", stop_en, 0);
    chk("R11 idle after ack", busy, 0);
    chk("R12 wcol sticky", wcol, 1);
    wcol_clr = 1; tick(); wcol_clr = 0;
    chk("R12 wcol cleared", wcol, 0);
    clear_irq();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule